// File: doc/BRIEF.md
# Lookup-Table Transient Fault Injector

This controller emulates a single-event transient in one lookup table of a programmable device. It works by editing the device's configuration frames through a word-wide configuration port. A fault descriptor names the column's base frame address, the parity of the slice row, the word inside the frame that holds the table bits, and which 16-bit half of that word to use. The controller then works on the four adjacent frames that hold the table contents. It first reads all four frames into a local buffer. It then writes them back with the selected field inverted in each frame. Finally it writes the untouched copies back, which ends the transient.

The configuration port is modelled as a memory of frames. Each access carries a frame address and a word index, and each word is transferred with a request/ready handshake. A frame holds 41 words of 32 bits. The word at index 20 belongs to the clock row and never holds table bits, so a descriptor that points at it, or past the end of the frame, is refused before any port traffic happens. The four frames are visited as one run: every word of a frame in ascending order, then the next frame.

Top module: `lut_set_injector`

## Requirements
- R1: Out of reset, `busy`, `done`, `err` and `cfg_req` are all low.
- R2: For an accepted descriptor, the first frame accessed is `d_base + 26` when `d_even` is 0 (odd slice row) and `d_base + 32` when `d_even` is 1. The result wraps modulo 2^ADDR_W, and the three later frames follow at +1, +2 and +3.
- R3: The read pass has `cfg_we` = 0 and covers frames first..first+3 with word indices 0..40 each. Word index advances fastest. The whole read pass finishes before any write starts.
- R4: The inverting pass uses the same frame and word order with `cfg_we` = 1. Each word is written with the value read from it, except the word at `d_word`. That word has bits 15:0 inverted when `d_lane` = 0 and bits 31:16 inverted when `d_lane` = 1.
- R5: The restore pass then writes every word of the four frames again in the same order, with its originally read value, so the frames end unchanged.
- R6: A word transfer completes only in a cycle where `cfg_req` and `cfg_ready` are both high. While `cfg_req` is high and `cfg_ready` is low, address, word index, direction and write data hold their values.
- R7: A start with `d_word` = 20 or `d_word` > 40 raises `err` for exactly one cycle, in the cycle after the start. `busy` stays low and no port access is made.
- R8: `start` is ignored while `busy` is high. The running injection keeps its descriptor and order.
- R9: `done` is a one-cycle pulse in the cycle after the last restore word completes. `busy` goes low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an injection with the descriptor on the d_* inputs |
| d_base | input | ADDR_W | Base frame address of the logic column |
| d_even | input | 1 | 1: slice row is even (frame offset 32); 0: odd (offset 26) |
| d_word | input | WIDX_W | Word index inside each frame holding the table bits |
| d_lane | input | LANE_W | Which 16-bit half of the word to invert (0 low, 1 high) |
| busy | output | 1 | Injection in progress |
| done | output | 1 | One-cycle pulse at the end of an injection |
| err | output | 1 | One-cycle pulse for a refused descriptor |
| cfg_req | output | 1 | Configuration port request |
| cfg_we | output | 1 | 1: write, 0: read |
| cfg_faddr | output | ADDR_W | Frame address of the current access |
| cfg_widx | output | WIDX_W | Word index inside the frame |
| cfg_wdata | output | DATA_W | Write data |
| cfg_rdata | input | DATA_W | Read data, valid when the read transfer completes |
| cfg_ready | input | 1 | Port accepts or delivers the current word |

## Verification
The bench builds the block with a 12-bit frame address and the default frame geometry, 41 words by 32 bits with four frames per table. With 12 bits, a base near the top of the address range makes the frame offset and the later frames wrap past zero, so wraparound is checked alongside the plain cases. Field offsets at both ends of the legal range (0 and 40) are exercised, as are the words on either side of the clock-row word. The bench also uses ready patterns that stall on most words, so the hold-stable behaviour and the per-word handshake are checked under heavy back-pressure.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_READ    = 2'd1,
      PH_FLIP    = 2'd2,
      PH_RESTORE = 2'd3
   } phase_t;

   // Pass sequence: read, inverted write-back, restore, idle.
   function automatic phase_t phase_after(input phase_t p);
      case (p)
         PH_READ:  return PH_FLIP;
         PH_FLIP:  return PH_RESTORE;
         default:  return PH_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/lsi_walker.sv
// Frame/word position counter for one pass over the adjacent frames.
module lsi_walker #(
   parameter int FRAMES = 4,
   parameter int WORDS  = 41,
   localparam int FIDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
   localparam int WIDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [FIDX_W-1:0] frame,
   output logic [WIDX_W-1:0] word,
   output logic              last
);

   localparam logic [FIDX_W-1:0] FRAME_END = FIDX_W'(FRAMES - 1);
   localparam logic [WIDX_W-1:0] WORD_END  = WIDX_W'(WORDS - 1);

   logic word_end;

   assign word_end = (word == WORD_END);
   assign last     = word_end && (frame == FRAME_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
         word  <= '0;
      end else if (clr) begin
         frame <= '0;
         word  <= '0;
      end else if (step) begin
         if (word_end) begin
            word  <= '0;
            frame <= last ? '0 : frame + 1'b1;
         end else begin
            word <= word + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lsi_frame_buf.sv
// Holds the words of all adjacent frames so the restore pass needs no re-read.
module lsi_frame_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 164,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[idx] <= wdata;
   end

   assign rdata = store[idx];

endmodule

// File: rtl/lsi_field_flip.sv
// Inverts one FIELD_W-wide lane of a word when enabled.
module lsi_field_flip #(
   parameter int DATA_W  = 32,
   parameter int FIELD_W = 16,
   localparam int LANES  = DATA_W / FIELD_W,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic              en,
   input  logic [LANE_W-1:0] lane,
   output logic [DATA_W-1:0] dout
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = en && (lane == LANE_W'(g));
      assign dout[g*FIELD_W +: FIELD_W] = din[g*FIELD_W +: FIELD_W] ^ {FIELD_W{hit}};
   end

endmodule

// File: rtl/lut_set_injector.sv
module lut_set_injector
   import lsi_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int FIELD_W     = 16,
   parameter int FRAME_WORDS = 41,
   parameter int LUT_FRAMES  = 4,
   parameter int ODD_OFS     = 26,
   parameter int EVEN_OFS    = 32,
   parameter int CLKROW_WORD = 20,
   localparam int WIDX_W     = $clog2(FRAME_WORDS),
   localparam int LANES      = DATA_W / FIELD_W,
   localparam int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] d_base,
   input  logic              d_even,
   input  logic [WIDX_W-1:0] d_word,
   input  logic [LANE_W-1:0] d_lane,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              cfg_req,
   output logic              cfg_we,
   output logic [ADDR_W-1:0] cfg_faddr,
   output logic [WIDX_W-1:0] cfg_widx,
   output logic [DATA_W-1:0] cfg_wdata,
   input  logic [DATA_W-1:0] cfg_rdata,
   input  logic              cfg_ready
);

   localparam int FIDX_W = (LUT_FRAMES > 1) ? $clog2(LUT_FRAMES) : 1;
   localparam int DEPTH  = LUT_FRAMES * FRAME_WORDS;
   localparam int BI_W   = $clog2(DEPTH);

   // Elaboration-time parameter checks
   if (DATA_W % FIELD_W != 0) begin : g_bad_field
      $error("DATA_W must be a whole multiple of FIELD_W");
   end
   if (CLKROW_WORD >= FRAME_WORDS) begin : g_bad_clkrow
      $error("clock-row word must lie inside the frame");
   end
   if (ODD_OFS + LUT_FRAMES > (1 << ADDR_W) || EVEN_OFS + LUT_FRAMES > (1 << ADDR_W)) begin : g_bad_ofs
      $error("frame offsets do not fit the address width");
   end

   phase_t            phase_q;
   logic [ADDR_W-1:0] first_q;
   logic [WIDX_W-1:0] word_q;
   logic [LANE_W-1:0] lane_q;
   logic              done_q;
   logic              err_q;

   logic              accept;
   logic              desc_ok;
   logic              beat;
   logic              last;
   logic [FIDX_W-1:0] frame_idx;
   logic [WIDX_W-1:0] word_idx;
   logic [BI_W-1:0]   buf_idx;
   logic [DATA_W-1:0] buf_rdata;
   logic              flip_en;
   logic [ADDR_W-1:0] first_d;

   assign accept  = start && (phase_q == PH_IDLE);
   assign desc_ok = (d_word != WIDX_W'(CLKROW_WORD)) && (d_word < WIDX_W'(FRAME_WORDS));
   assign first_d = d_base + (d_even ? ADDR_W'(EVEN_OFS) : ADDR_W'(ODD_OFS));

   assign cfg_req = (phase_q != PH_IDLE);
   assign cfg_we  = (phase_q == PH_FLIP) || (phase_q == PH_RESTORE);
   assign beat    = cfg_req && cfg_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         first_q <= '0;
         word_q  <= '0;
         lane_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (desc_ok) begin
               phase_q <= PH_READ;
               first_q <= first_d;
               word_q  <= d_word;
               lane_q  <= d_lane;
            end else begin
               err_q <= 1'b1;
            end
         end else if (beat && last) begin
            phase_q <= phase_after(phase_q);
            if (phase_q == PH_RESTORE) done_q <= 1'b1;
         end
      end
   end

   lsi_walker #(
      .FRAMES (LUT_FRAMES),
      .WORDS  (FRAME_WORDS)
   ) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .step  (beat),
      .frame (frame_idx),
      .word  (word_idx),
      .last  (last)
   );

   assign buf_idx = BI_W'(frame_idx) * BI_W'(FRAME_WORDS) + BI_W'(word_idx);

   lsi_frame_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_buf (
      .clk   (clk),
      .we    (beat && (phase_q == PH_READ)),
      .idx   (buf_idx),
      .wdata (cfg_rdata),
      .rdata (buf_rdata)
   );

   assign flip_en = (phase_q == PH_FLIP) && (word_idx == word_q);

   lsi_field_flip #(
      .DATA_W  (DATA_W),
      .FIELD_W (FIELD_W)
   ) u_flip (
      .din  (buf_rdata),
      .en   (flip_en),
      .lane (lane_q),
      .dout (cfg_wdata)
   );

   assign cfg_faddr = first_q + ADDR_W'(frame_idx);
   assign cfg_widx  = word_idx;
   assign busy      = (phase_q != PH_IDLE);
   assign done      = done_q;
   assign err       = err_q;

endmodule

// File: rtl/lsi_checker.sv
module lsi_checker #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int FRAME_WORDS = 41,
   localparam int WIDX_W     = $clog2(FRAME_WORDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              cfg_req,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_faddr,
   input logic [WIDX_W-1:0] cfg_widx,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              cfg_ready
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cfg_req); // R1

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_ready) |=> (cfg_req && $stable(cfg_faddr) && $stable(cfg_widx)
                                   && $stable(cfg_we) && $stable(cfg_wdata))); // R6

   AST_WORD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (cfg_widx < WIDX_W'(FRAME_WORDS))); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R9

   AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !cfg_req && $past(start) && !$past(busy))); // R7

   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R7

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R8

   AST_NO_DONE_AND_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R7

endmodule

bind lut_set_injector lsi_checker #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .FRAME_WORDS (FRAME_WORDS)
) u_chk (.*);

// File: tb/sim_lut_set_injector.sv
`timescale 1ns/1ps
module sim_lut_set_injector;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam int NW = 41;
   localparam int WW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] d_base = '0;
   logic          d_even = 1'b0;
   logic [WW-1:0] d_word = '0;
   logic          d_lane = 1'b0;
   logic          busy, done, err, cfg_req, cfg_we;
   logic [AW-1:0] cfg_faddr;
   logic [WW-1:0] cfg_widx;
   logic [DW-1:0] cfg_wdata;
   logic [DW-1:0] cfg_rdata = '0;
   logic          cfg_ready = 1'b0;

   lut_set_injector #(.ADDR_W(AW)) u0 (
      .clk, .rst_n, .start, .d_base, .d_even, .d_word, .d_lane,
      .busy, .done, .err, .cfg_req, .cfg_we, .cfg_faddr, .cfg_widx,
      .cfg_wdata, .cfg_rdata, .cfg_ready
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int ready_mode = 0;
   bit finished = 0;

   typedef struct {
      int          fa;
      int          wi;
      bit          we;
      logic [31:0] data;
   } acc_t;

   acc_t        q[$];
   logic [31:0] mem [int];
   bit          mbusy = 0;
   bit          exp_done = 0, exp_err = 0;
   bit          pend_fire = 0, pend_start = 0;
   int          pf_fa, pf_wi;
   logic [31:0] pf_wd;
   logic [AW-1:0] ps_base;
   bit          ps_even, ps_lane;
   int          ps_word;

   function automatic logic [31:0] seed(int fa, int wi);
      return 32'h5A3C_0000 ^ (fa * 32'h0001_9E37) ^ (wi * 32'h0101_0107);
   endfunction

   function automatic logic [31:0] rd_mem(int fa, int wi);
      int k = fa * 64 + wi;
      if (mem.exists(k)) return mem[k];
      return seed(fa, wi);
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic bit desc_valid(int w);
      return (w != 20) && (w <= 40);
   endfunction

   task automatic build_queue(logic [AW-1:0] b, bit ev, int w, bit ln);
      int f0 = (int'(b) + (ev ? 32 : 26)) % (1 << AW);
      for (int p = 0; p < 3; p++)
         for (int f = 0; f < 4; f++)
            for (int i = 0; i < NW; i++) begin
               acc_t a;
               logic [31:0] o;
               a.fa = (f0 + f) % (1 << AW);
               a.wi = i;
               o = rd_mem(a.fa, i);
               a.we = (p != 0);
               a.data = o;
               if (p == 1 && i == w) a.data = o ^ (ln ? 32'hFFFF_0000 : 32'h0000_FFFF);
               q.push_back(a);
            end
   endtask

   // Cycle-by-cycle reference model and configuration memory
   always @(negedge clk) begin
      #2;
      cyc++;
      if (!rst_n) begin
         q.delete();
         mbusy = 0; exp_done = 0; exp_err = 0; pend_fire = 0; pend_start = 0;
         cfg_ready = 1'b0;
      end else begin
         exp_done = 0;
         exp_err  = 0;
         if (pend_fire) begin
            acc_t a;
            if (q.size() > 0) begin
               a = q.pop_front();
               if (a.we) mem[pf_fa * 64 + pf_wi] = pf_wd;
            end
            if (q.size() == 0) begin
               mbusy = 0;
               exp_done = 1;
            end
         end
         if (pend_start) begin
            if (desc_valid(ps_word)) begin
               mbusy = 1;
               build_queue(ps_base, ps_even, ps_word, ps_lane);
            end else begin
               exp_err = 1;
            end
         end
         // status outputs: R1 idle, R7 error pulse, R8 busy tracking, R9 done pulse
         check(busy == mbusy && done == exp_done && err == exp_err,
               "R1,R7,R8,R9 status busy/done/err",
               {61'b0, busy, done, err}, {61'b0, mbusy, exp_done, exp_err});
         // port access: R2 frame, R3 order, R4 inversion, R5 restore, R6 hold
         if (mbusy && q.size() > 0) begin
            bit ok;
            ok = cfg_req && int'(cfg_faddr) == q[0].fa && int'(cfg_widx) == q[0].wi
                 && cfg_we == q[0].we && (!q[0].we || cfg_wdata == q[0].data);
            check(ok, "R2,R3,R4,R5,R6 access addr/word/we/data",
                  {cfg_we, 13'b0, 4'b0, cfg_faddr, 2'b0, cfg_widx, cfg_wdata},
                  {q[0].we, 13'b0, 4'b0, AW'(q[0].fa), 2'b0, WW'(q[0].wi), q[0].data});
         end else begin
            check(!cfg_req, "R1,R7 no port access while idle", {63'b0, cfg_req}, 64'd0);
         end
         cfg_rdata = rd_mem(int'(cfg_faddr), int'(cfg_widx));
         case (ready_mode)
            1:       cfg_ready = (cyc % 3 == 0);
            2:       cfg_ready = (cyc % 5 != 2);
            default: cfg_ready = 1'b1;
         endcase
         pend_fire = cfg_req && cfg_ready;
         pf_fa = int'(cfg_faddr);
         pf_wi = int'(cfg_widx);
         pf_wd = cfg_wdata;
         pend_start = start && !mbusy;
         ps_base = d_base; ps_even = d_even; ps_word = int'(d_word); ps_lane = d_lane;
      end
   end

   task automatic kick(logic [AW-1:0] b, bit ev, int w, bit ln);
      @(negedge clk);
      start = 1'b1; d_base = b; d_even = ev; d_word = WW'(w); d_lane = ln;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 20000; n++) begin
         @(negedge clk);
         #5;
         if (!mbusy && !pend_fire && !pend_start && !busy) return;
      end
   endtask

   task automatic check_restored(logic [AW-1:0] b, bit ev);
      int f0 = (int'(b) + (ev ? 32 : 26)) % (1 << AW);
      int diffs = 0;
      for (int f = 0; f < 4; f++)
         for (int i = 0; i < NW; i++)
            if (rd_mem((f0 + f) % (1 << AW), i) != seed((f0 + f) % (1 << AW), i)) diffs++;
      check(diffs == 0, "R5 frames restored after injection", 64'(diffs), 64'd0);
   endtask

   task automatic run_one(logic [AW-1:0] b, bit ev, int w, bit ln, int mode);
      ready_mode = mode;
      kick(b, ev, w, ln);
      wait_idle();
      check_restored(b, ev);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !err && !cfg_req, "R1 reset state",
            {60'b0, busy, done, err, cfg_req}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !cfg_req, "R1 idle after reset", {62'b0, busy, cfg_req}, 64'd0);

      // R2 odd row, R4 low lane, full-rate port
      run_one(12'h100, 1'b0, 5, 1'b0, 0);
      // R2 even row, R4 high lane at the last word, R6 heavy stalls
      run_one(12'h240, 1'b1, 40, 1'b1, 1);
      // word 0 and the words around the clock row
      run_one(12'h011, 1'b1, 0, 1'b1, 2);
      run_one(12'h300, 1'b0, 19, 1'b0, 2);
      run_one(12'h300, 1'b0, 21, 1'b1, 0);
      // R2 wraparound of the frame address
      run_one(12'hFF0, 1'b1, 7, 1'b0, 1);
      run_one(12'hFE8, 1'b0, 12, 1'b1, 0);

      // R7 refused descriptors
      ready_mode = 0;
      kick(12'h100, 1'b0, 20, 1'b0);
      wait_idle();
      kick(12'h100, 1'b1, 41, 1'b1);
      wait_idle();
      kick(12'h100, 1'b1, 63, 1'b0);
      wait_idle();
      check(!busy && !cfg_req, "R7 no activity after refused start", {62'b0, busy, cfg_req}, 64'd0);

      // R8 start pulses during a run are ignored
      ready_mode = 2;
      kick(12'h500, 1'b0, 3, 1'b1);
      repeat (30) @(negedge clk);
      kick(12'h700, 1'b1, 9, 1'b0);
      repeat (200) @(negedge clk);
      kick(12'h710, 1'b1, 20, 1'b0);
      wait_idle();
      check_restored(12'h500, 1'b0);
      check(!mem.exists(((12'h700 + 32) % 4096) * 64 + 9),
            "R8 ignored descriptor left its frames untouched", 64'd0, 64'd0);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule